// File: doc/BRIEF.md
# Program Status Register with Privilege-Checked Writes

This block holds a processor's 32-bit current status word: four arithmetic condition flags, a sticky saturation flag, two instruction-set selection bits, the normal and fast interrupt mask bits and a 5-bit operating mode. Four sources update it. Software writes arrive with a four-bit lane select, one bit per byte of the word. The arithmetic unit loads new condition flags. A saturation pulse sets the sticky flag. A hardware exception-entry port switches the mode and masks interrupts.

Each software write is filtered by the privilege of the mode held in the register. Any mode other than the unprivileged application mode may rewrite every implemented bit. The unprivileged mode can change only the four condition flags and the saturation flag. Its writes to the mode, mask and state bits are dropped. Bits with no function always read zero. Downstream logic reads the word directly, along with decoded outputs for privilege, the two interrupt blocks and the active instruction set.

Top module: `psr_status_reg`

## Requirements
- R1: After reset the register reads 0x000000D3: mode 5'b10011 (supervisor), bit 7 (I) and bit 6 (F) set, bit 5 (T) and bit 24 (J) clear, flags clear.
- R2: In any mode other than 5'b10000, a software write copies the data bits of each selected lane into the register. Lane bit 3 selects bits 31:24, bit 2 selects 23:16, bit 1 selects 15:8 and bit 0 selects 7:0. Only implemented bits are copied: 31:27, 24 and 7:0.
- R3: In mode 5'b10000, a software write with lane bit 3 set updates bits 31:27 (N, Z, C, V, Q). It leaves bit 24 and bits 7:0 unchanged.
- R4: Bits 26:25 and 23:8 always read zero.
- R5: When the flag-update enable is high, bits 31:28 take alu_flags[3:0] in N, Z, C, V order. An accepted software write with lane bit 3 set in the same cycle overrides this update.
- R6: A saturation pulse sets bit 27 (Q). Q stays set until a software write with lane bit 3 set writes it to 0. If a pulse and a clearing write arrive in the same cycle, Q ends set.
- R7: An exception load sets the mode to exc_mode, sets I, ORs exc_mask_fast into F, and clears T and J. Bits 31:27 are left to R5 and R6.
- R8: A software write issued in the same cycle as an exception load is discarded completely.
- R9: irq_blocked follows bit 7 and fiq_blocked follows bit 6. iset is {J,T}: 00 selects the base set, 01 the compact set, 10 the byte-code set and 11 is invalid. priv_mode is high when the mode is not 5'b10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Software write request |
| sw_lane_sel | input | 4 | Byte lanes targeted by the write |
| sw_wr_data | input | 32 | Software write data |
| alu_flag_en | input | 1 | Load N, Z, C, V from the arithmetic unit |
| alu_flags | input | 4 | New N, Z, C, V values |
| sat_set | input | 1 | Set the sticky saturation flag |
| exc_load_en | input | 1 | Exception entry |
| exc_mode | input | 5 | Mode to enter on exception |
| exc_mask_fast | input | 1 | Also mask fast interrupts on entry |
| psr_q | output | 32 | Current register value |
| priv_mode | output | 1 | Current mode is privileged |
| irq_blocked | output | 1 | Normal interrupts masked |
| fiq_blocked | output | 1 | Fast interrupts masked |
| iset | output | 2 | Active instruction set {J,T} |

## Verification
The collision that matters is an exception load landing in the same cycle as a software write. The bench forces this from every mode, with all lanes selected, all-ones data and both values of the fast-mask input. It then checks that no written bit got through and that the entry values are present. A second overlap, a software flag write against an arithmetic flag load or a saturation pulse, is swept over all sixteen flag patterns. Each case is judged against a reference next-state function built from the requirements.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int PSR_W  = LANES * LANE_W;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } psr_mode_e;

  localparam int BIT_N = 31;
  localparam int BIT_Q = 27;
  localparam int BIT_J = 24;
  localparam int BIT_I = 7;
  localparam int BIT_F = 6;
  localparam int BIT_T = 5;

  // implemented bits, and the subset an unprivileged write may reach
  localparam logic [PSR_W-1:0] IMPL_ALL  = 32'hF900_00FF;
  localparam logic [PSR_W-1:0] IMPL_USER = 32'hF800_0000;

  function automatic logic mode_is_priv(logic [4:0] m);
    return m != MODE_USR;
  endfunction

  function automatic logic [PSR_W-1:0] reset_word(logic [4:0] m);
    logic [PSR_W-1:0] r;
    r = '0;
    r[4:0]  = m;
    r[BIT_I] = 1'b1;
    r[BIT_F] = 1'b1;
    return r;
  endfunction

  function automatic logic [PSR_W-1:0] merge_masked(logic [PSR_W-1:0] cur,
                                                    logic [PSR_W-1:0] data,
                                                    logic [PSR_W-1:0] mask);
    return (cur & ~mask) | (data & mask);
  endfunction

  function automatic logic [PSR_W-1:0] enter_exception(logic [PSR_W-1:0] cur,
                                                       logic [4:0] m,
                                                       logic mask_fast);
    logic [PSR_W-1:0] r;
    r = cur;
    r[4:0]   = m;
    r[BIT_I] = 1'b1;
    r[BIT_F] = cur[BIT_F] | mask_fast;
    r[BIT_T] = 1'b0;
    r[BIT_J] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/psr_access_ctl.sv
module psr_access_ctl
  import psr_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int L_W     = LANE_W,
  localparam int W      = N_LANES * L_W
) (
  input  logic [4:0]         cur_mode,
  input  logic               sw_wr_en,
  input  logic [N_LANES-1:0] lane_sel,
  input  logic               exc_load_en,
  output logic               sw_grant,
  output logic               flags_lane_hit,
  output logic [W-1:0]       wr_mask
);

  logic         priv;
  logic [W-1:0] lane_bits;
  logic [W-1:0] allowed;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign lane_bits[g*L_W +: L_W] = {L_W{lane_sel[g]}};
  end

  assign priv           = mode_is_priv(cur_mode);
  assign allowed        = priv ? IMPL_ALL : IMPL_USER;
  assign sw_grant       = sw_wr_en & ~exc_load_en;
  assign flags_lane_hit = sw_grant & lane_sel[N_LANES-1];
  assign wr_mask        = sw_grant ? (lane_bits & allowed) : '0;

endmodule

// File: rtl/psr_next_calc.sv
module psr_next_calc
  import psr_pkg::*;
#(
  parameter int W = PSR_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wr_mask,
  input  logic [W-1:0] wr_data,
  input  logic         flags_lane_hit,
  input  logic         alu_flag_en,
  input  logic [3:0]   alu_flags,
  input  logic         sat_set,
  input  logic         exc_load_en,
  input  logic [4:0]   exc_mode,
  input  logic         exc_mask_fast,
  output logic         alu_applied,
  output logic [W-1:0] nxt
);

  logic [W-1:0] stage;

  assign alu_applied = alu_flag_en & ~flags_lane_hit;

  always_comb begin
    stage = merge_masked(cur, wr_data, wr_mask);
    if (exc_load_en) stage = enter_exception(stage, exc_mode, exc_mask_fast);
    if (alu_applied) stage[BIT_N -: 4] = alu_flags;
    if (sat_set)     stage[BIT_Q] = 1'b1;
    nxt = stage & IMPL_ALL;
  end

endmodule

// File: rtl/psr_view.sv
module psr_view
  import psr_pkg::*;
#(
  parameter int W = PSR_W
) (
  input  logic [W-1:0] psr,
  output logic         priv_mode,
  output logic         irq_blocked,
  output logic         fiq_blocked,
  output logic [1:0]   iset
);

  assign priv_mode   = mode_is_priv(psr[4:0]);
  assign irq_blocked = psr[BIT_I];
  assign fiq_blocked = psr[BIT_F];
  assign iset        = {psr[BIT_J], psr[BIT_T]};

endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
  import psr_pkg::*;
#(
  parameter logic [4:0] RESET_MODE = MODE_SVC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_en,
  input  logic [LANES-1:0]  sw_lane_sel,
  input  logic [PSR_W-1:0]  sw_wr_data,
  input  logic              alu_flag_en,
  input  logic [3:0]        alu_flags,
  input  logic              sat_set,
  input  logic              exc_load_en,
  input  logic [4:0]        exc_mode,
  input  logic              exc_mask_fast,
  output logic [PSR_W-1:0]  psr_q,
  output logic              priv_mode,
  output logic              irq_blocked,
  output logic              fiq_blocked,
  output logic [1:0]        iset
);

  localparam logic [PSR_W-1:0] RST_VAL = reset_word(RESET_MODE);

  logic             sw_grant;
  logic             flags_lane_hit;
  logic             alu_applied;
  logic [PSR_W-1:0] wr_mask;
  logic [PSR_W-1:0] psr_d;

  psr_access_ctl u_acc (
    .cur_mode       (psr_q[4:0]),
    .sw_wr_en       (sw_wr_en),
    .lane_sel       (sw_lane_sel),
    .exc_load_en    (exc_load_en),
    .sw_grant       (sw_grant),
    .flags_lane_hit (flags_lane_hit),
    .wr_mask        (wr_mask)
  );

  psr_next_calc u_nxt (
    .cur            (psr_q),
    .wr_mask        (wr_mask),
    .wr_data        (sw_wr_data),
    .flags_lane_hit (flags_lane_hit),
    .alu_flag_en    (alu_flag_en),
    .alu_flags      (alu_flags),
    .sat_set        (sat_set),
    .exc_load_en    (exc_load_en),
    .exc_mode       (exc_mode),
    .exc_mask_fast  (exc_mask_fast),
    .alu_applied    (alu_applied),
    .nxt            (psr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psr_q <= RST_VAL;
    else        psr_q <= psr_d;
  end

  psr_view u_view (
    .psr         (psr_q),
    .priv_mode   (priv_mode),
    .irq_blocked (irq_blocked),
    .fiq_blocked (fiq_blocked),
    .iset        (iset)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q & ~IMPL_ALL) == '0); // R4

  AST_USER_CTRL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_load_en && !priv_mode) |=> psr_q[7:0] == $past(psr_q[7:0])); // R3

  AST_USER_J_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_load_en && !priv_mode) |=> psr_q[BIT_J] == $past(psr_q[BIT_J])); // R3

  AST_ALU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    alu_applied |=> psr_q[BIT_N -: 4] == $past(alu_flags)); // R5

  AST_SAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sat_set |=> psr_q[BIT_Q]); // R6

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q[BIT_Q] && !flags_lane_hit) |=> psr_q[BIT_Q]); // R6

  AST_EXC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    exc_load_en |=> (psr_q[4:0] == $past(exc_mode)) && psr_q[BIT_I]
                    && !psr_q[BIT_T] && !psr_q[BIT_J]); // R7

  AST_EXC_DROPS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_load_en && !alu_flag_en && !sat_set)
      |=> psr_q[31:27] == $past(psr_q[31:27])); // R8

endmodule

// File: tb/tb_psr_status_reg.sv
module tb_psr_status_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [3:0]  sw_lane_sel = '0;
  logic [31:0] sw_wr_data = '0;
  logic        alu_flag_en = 1'b0;
  logic [3:0]  alu_flags = '0;
  logic        sat_set = 1'b0;
  logic        exc_load_en = 1'b0;
  logic [4:0]  exc_mode = '0;
  logic        exc_mask_fast = 1'b0;
  logic [31:0] psr_q;
  logic        priv_mode, irq_blocked, fiq_blocked;
  logic [1:0]  iset;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mdl;
  logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111};
  logic [31:0] pats [3] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'hA5C3_3C2A};

  always #2 clk = ~clk;

  psr_status_reg dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_lane_sel(sw_lane_sel),
    .sw_wr_data(sw_wr_data), .alu_flag_en(alu_flag_en), .alu_flags(alu_flags),
    .sat_set(sat_set), .exc_load_en(exc_load_en), .exc_mode(exc_mode),
    .exc_mask_fast(exc_mask_fast), .psr_q(psr_q), .priv_mode(priv_mode),
    .irq_blocked(irq_blocked), .fiq_blocked(fiq_blocked), .iset(iset)
  );

  // reference next value, stated from the requirements
  function automatic logic [31:0] ref_next(logic [31:0] m, logic sw, logic [3:0] bm,
      logic [31:0] d, logic ae, logic [3:0] af, logic sat, logic ex,
      logic [4:0] em, logic ef);
    logic [31:0] r;
    logic p;
    r = m;
    p = (m[4:0] != 5'b10000);
    if (ex) begin
      r[4:0] = em; r[7] = 1'b1; r[6] = m[6] | ef; r[5] = 1'b0; r[24] = 1'b0;
    end else if (sw) begin
      if (bm[3]) begin
        r[31:27] = d[31:27];
        if (p) r[24] = d[24];
      end
      if (bm[0] && p) r[7:0] = d[7:0];
    end
    if (ae && !(sw && !ex && bm[3])) r[31:28] = af;
    if (sat) r[27] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_view(string tag);
    chk({tag, "/R9"}, {26'd0, priv_mode, irq_blocked, fiq_blocked, 1'b0, iset},
        {26'd0, mdl[4:0] != 5'b10000, mdl[7], mdl[6], 1'b0, mdl[24], mdl[5]});
  endtask

  // called at a negative edge; applies one cycle and returns at the next negative edge
  task automatic step(logic sw, logic [3:0] bm, logic [31:0] d, logic ae,
                      logic [3:0] af, logic sat, logic ex, logic [4:0] em, logic ef);
    sw_wr_en = sw; sw_lane_sel = bm; sw_wr_data = d; alu_flag_en = ae;
    alu_flags = af; sat_set = sat; exc_load_en = ex; exc_mode = em;
    exc_mask_fast = ef;
    mdl = ref_next(mdl, sw, bm, d, ae, af, sat, ex, em, ef);
    @(negedge clk);
    sw_wr_en = 1'b0; alu_flag_en = 1'b0; sat_set = 1'b0; exc_load_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    mdl = 32'h0000_00D3;
    chk("R1 reset value", psr_q, 32'h0000_00D3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", psr_q, mdl);
    chk_view("R1");

    // lane/permission sweep over every mode, lane select and pattern
    for (int mi = 0; mi < 7; mi++) begin
      for (int bm = 0; bm < 16; bm++) begin
        for (int pi = 0; pi < 3; pi++) begin
          step(1'b0, 4'h0, '0, 1'b0, 4'h0, 1'b0, 1'b1, 5'b10011, 1'b0);
          step(1'b1, 4'h9, {8'h00, 16'h0, 3'b000, modes[mi]}, 1'b0, 4'h0,
               1'b0, 1'b0, 5'b0, 1'b0);
          chk("R2 setup mode", psr_q, mdl);
          step(1'b1, 4'(bm), pats[pi], 1'b0, 4'h0, 1'b0, 1'b0, 5'b0, 1'b0);
          if (mi == 0) chk("R3 user write", psr_q, mdl);
          else         chk("R2 priv write", psr_q, mdl);
          chk("R4 reserved zero", psr_q & 32'h06FF_FF00, 32'h0);
          chk_view("R9 decode");
        end
      end
    end

    // arithmetic flag loads, alone and against a flag-lane write
    for (int mi = 0; mi < 2; mi++) begin
      step(1'b0, 4'h0, '0, 1'b0, 4'h0, 1'b0, 1'b1, 5'b10011, 1'b0);
      step(1'b1, 4'h1, {24'h0, 3'b000, modes[mi * 3]}, 1'b0, 4'h0, 1'b0,
           1'b0, 5'b0, 1'b0);
      for (int f = 0; f < 16; f++) begin
        step(1'b0, 4'h0, '0, 1'b1, 4'(f), 1'b0, 1'b0, 5'b0, 1'b0);
        chk("R5 alu load", psr_q, mdl);
        step(1'b1, 4'h8, {4'(~f), 28'h0}, 1'b1, 4'(f), 1'b0, 1'b0, 5'b0, 1'b0);
        chk("R5 sw write wins", psr_q, mdl);
        step(1'b1, 4'h7, 32'hFFFF_FFFF, 1'b1, 4'(f), 1'b0, 1'b0, 5'b0, 1'b0);
        chk("R5 alu with non-flag lanes", psr_q, mdl);
      end
    end

    // sticky saturation flag, from user mode
    step(1'b0, 4'h0, '0, 1'b0, 4'h0, 1'b0, 1'b1, 5'b10011, 1'b0);
    step(1'b1, 4'h1, 32'h0000_0010, 1'b0, 4'h0, 1'b0, 1'b0, 5'b0, 1'b0);
    step(1'b0, 4'h0, '0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b0, 1'b0);
    chk("R6 sat set", psr_q[27], 1'b1);
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 4'h7, 32'h0, 1'b1, 4'(k), 1'b0, 1'b0, 5'b0, 1'b0);
      chk("R6 Q holds", psr_q, mdl);
    end
    step(1'b0, 4'h0, '0, 1'b0, 4'h0, 1'b0, 1'b1, 5'b10010, 1'b1);
    chk("R6 Q holds across exception", psr_q[27], 1'b1);
    step(1'b1, 4'h8, 32'h0, 1'b0, 4'h0, 1'b1, 1'b0, 5'b0, 1'b0);
    chk("R6 set beats clear", psr_q[27], 1'b1);
    step(1'b1, 4'h8, 32'h0, 1'b0, 4'h0, 1'b0, 1'b0, 5'b0, 1'b0);
    chk("R6 explicit clear", psr_q[27], 1'b0);
    chk("R6 full word", psr_q, mdl);

    // exception entry colliding with a software write
    for (int mi = 0; mi < 7; mi++) begin
      for (int ef = 0; ef < 2; ef++) begin
        step(1'b0, 4'h0, '0, 1'b0, 4'h0, 1'b0, 1'b1, 5'b10011, 1'b0);
        step(1'b1, 4'hF, {5'b01010, 2'b00, 1'b1, 16'h0, 3'b001, modes[mi]},
             1'b0, 4'h0, 1'b0, 1'b0, 5'b0, 1'b0);
        chk("R2 pre-exception state", psr_q, mdl);
        step(1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 4'h0, 1'b0, 1'b1,
             modes[(mi + 2) % 7], 1'(ef));
        chk("R8 write dropped on exception", psr_q, mdl);
        chk("R7 entry fields", {psr_q[24], psr_q[7:0]},
            {1'b0, 1'b1, 1'(ef), 1'b0, modes[(mi + 2) % 7]});
        chk_view("R7 decode");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule